// File: doc/BRIEF.md
# I2C Master Condition Sequencer

This block is a bus-side engine for an I2C master. Software asks for exactly one bus event at a time by setting a command bit in a small control register. The events are a Start, a Repeated Start, a Stop, the reception of one byte, and a single acknowledge clock. The command bit reads back as 1 for as long as the event runs. It drops to 0 by itself when the event ends. Writing a byte to the transmit register while the engine is idle starts a nine-clock transfer: eight data bits, most significant bit first, then one clock on which the slave's acknowledge is sampled.

The engine drives both open-drain lines through active-high pull-low enables, and it reads SDA back. Every phase of SCL, low or high, lasts a programmable number of system clocks. A one-cycle interrupt pulse marks the end of every event. While an event is in progress the engine accepts no new work: command requests, transmit-register writes and divider writes are dropped rather than held back.

Top module: `i2c_seq_master`

## Requirements
- R1: After reset, every register reads 0 (control, transmit, receive, divider), both line enables are 0 (released), and the interrupt is 0.
- R2: Writing control bit 0 (Start) while idle holds both lines released for one phase, then pulls SDA low with SCL still released for one phase, then pulls SCL low for one phase. This is three phases in total, and the engine finishes with both enables at 1.
- R3: Control bit 1 (Repeated Start) runs four phases. SDA is released with SCL low, then SCL is released, then SDA is pulled low while SCL stays released, then SCL is pulled low. This makes exactly one SDA fall while SCL is high.
- R4: Control bit 2 (Stop) runs three phases. SDA is pulled low with SCL low, then SCL is released, then SDA is released. This makes exactly one SDA rise while SCL is high, and both enables end at 0.
- R5: Writing register 1 (transmit) while idle sends the byte MSB first on eight SCL clocks, releases SDA on a ninth clock, and takes 18 phases. The written value reads back from register 1.
- R6: Control bit 6 is read-only. After a transmit it holds the SDA level sampled on the ninth clock: 1 means no acknowledge, 0 means acknowledge.
- R7: Control bit 3 (Receive) runs eight SCL clocks with SDA released. SDA is sampled at the end of each high phase, MSB first. The byte appears in register 2 (receive) after 16 phases.
- R8: Control bit 4 (Acknowledge) runs one SCL clock (2 phases). SDA carries bit 5 of the same write: 0 pulls SDA low (ACK), 1 leaves it released (NACK).
- R9: Each SCL phase lasts DIV+1 system clocks, where DIV is the value in register 3. An event of P phases raises its interrupt P·(DIV+1) clocks after the accepting edge.
- R10: During a transmit, receive or acknowledge event, SDA changes only while SCL is pulled low.
- R11: The interrupt is high for exactly one cycle, in the cycle that follows the end of the last phase of every event. At that point all command bits read 0.
- R12: While an event runs, writes to the command bits, to register 1 and to register 3 are ignored. The running event, the transmit value and the divider all stay unchanged, and no event follows.
- R13: When several command bits are set in one write, only one is accepted, in the priority Start, Repeated Start, Stop, Receive, Acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_addr | input | 2 | Register select: 0 control, 1 transmit, 2 receive, 3 divider |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register (combinational) |
| sda_in | input | 1 | Level sensed on the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| irq | output | 1 | One-cycle pulse at the end of each event |

## Verification
The bench builds the block with its defaults, an 8-bit data path and an 8-bit divider, and programs divider values 0 to 3. At divider 0, every one of the 256 byte values is sent and received, and the slave's acknowledge alternates with the byte's low bit. The larger dividers repeat a handful of edge patterns and check that event lengths scale as phases·(DIV+1). A line monitor counts Start and Stop edges and SDA movements while SCL is high. The refusal and priority cases are driven from a long receive and from multi-bit control writes.

// File: rtl/i2c_seq_pkg.sv
`timescale 1ns/1ps
package i2c_seq_pkg;

    // Event codes. Command bit i of the control register maps to code i+1,
    // so the bit order is also the acceptance priority.
    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_START  = 3'd1,
        OP_RSTART = 3'd2,
        OP_STOP   = 3'd3,
        OP_RX     = 3'd4,
        OP_ACK    = 3'd5,
        OP_TX     = 3'd6
    } op_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_TX   = 2'd1;
    localparam logic [1:0] ADDR_RX   = 2'd2;
    localparam logic [1:0] ADDR_DIV  = 2'd3;

    localparam int CMD_BITS     = 5;
    localparam int BIT_ACK_LVL  = 5;
    localparam int BIT_ACK_STAT = 6;

    // Events that clock bits through the shift register
    function automatic logic is_bit_op(op_e op);
        return (op == OP_RX) || (op == OP_ACK) || (op == OP_TX);
    endfunction

endpackage

// File: rtl/i2c_phase_timer.sv
`timescale 1ns/1ps
module i2c_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         tick
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == limit);
        cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R9: inside a phase the counter advances by one each clock
    a_r9_phase_count: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R9: an idle timer stays at zero
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/i2c_cmd_pick.sv
`timescale 1ns/1ps
module i2c_cmd_pick
    import i2c_seq_pkg::*;
#(
    parameter int N_CMD = CMD_BITS
) (
    input  logic [N_CMD-1:0] req,
    output op_e              op,
    output logic             any
);

    // Lowest set bit wins (R13)
    always_comb begin
        op = OP_IDLE;
        for (int i = N_CMD - 1; i >= 0; i--) begin
            if (req[i]) op = op_e'(3'(i + 1));
        end
        any = |req;
    end

endmodule

// File: rtl/i2c_seq_master.sv
`timescale 1ns/1ps
module i2c_seq_master
    import i2c_seq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              irq
);

    localparam int SH_W   = DATA_W + 1;
    localparam int STEP_W = $clog2(2 * SH_W);

    typedef struct packed {
        op_e               op;
        logic [STEP_W-1:0] step;
        logic [SH_W-1:0]   sh;
        logic              scl_oe;
        logic              sda_oe;
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
        logic [DIV_W-1:0]  div;
        logic              ack_lvl;
        logic              ack_stat;
        logic              irq;
    } st_t;

    st_t  st_d, st_q;
    logic busy, tick, pick_any;
    op_e  pick_op;

    assign busy = (st_q.op != OP_IDLE);

    i2c_phase_timer #(.W(DIV_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .limit (st_q.div),
        .tick  (tick)
    );

    i2c_cmd_pick #(.N_CMD(CMD_BITS)) u_pick (
        .req (reg_wdata[CMD_BITS-1:0]),
        .op  (pick_op),
        .any (pick_any)
    );

    // Index of the final phase of each event
    function automatic logic [STEP_W-1:0] last_step(op_e op);
        case (op)
            OP_START:  return STEP_W'(2);
            OP_RSTART: return STEP_W'(3);
            OP_STOP:   return STEP_W'(2);
            OP_ACK:    return STEP_W'(1);
            OP_RX:     return STEP_W'(2 * DATA_W - 1);
            OP_TX:     return STEP_W'(2 * DATA_W + 1);
            default:   return '0;
        endcase
    endfunction

    // Line enables {scl, sda} for a phase; 1 pulls the line low
    function automatic logic [1:0] drive(op_e op, logic [STEP_W-1:0] st, logic bit_msb);
        case (op)
            OP_START:  return (st == 0) ? 2'b00 : (st == 1) ? 2'b01 : 2'b11;
            OP_RSTART: return (st == 0) ? 2'b10 : (st == 1) ? 2'b00 :
                              (st == 2) ? 2'b01 : 2'b11;
            OP_STOP:   return (st == 0) ? 2'b11 : (st == 1) ? 2'b01 : 2'b00;
            OP_RX, OP_ACK, OP_TX: return {~st[0], ~bit_msb};
            default:   return 2'b00;
        endcase
    endfunction

    always_comb begin
        logic [SH_W-1:0] sh_nx;
        logic [1:0]      drv;
        st_d     = st_q;
        st_d.irq = 1'b0;
        sh_nx    = {st_q.sh[DATA_W-1:0], sda_in};
        drv      = 2'b00;
        if (busy) begin
            if (tick) begin
                if (st_q.step == last_step(st_q.op)) begin
                    if (is_bit_op(st_q.op)) begin
                        st_d.sh     = sh_nx;
                        st_d.scl_oe = 1'b1;
                    end
                    if (st_q.op == OP_RX) st_d.rx       = sh_nx[DATA_W-1:0];
                    if (st_q.op == OP_TX) st_d.ack_stat = sda_in;
                    st_d.op   = OP_IDLE;
                    st_d.step = '0;
                    st_d.irq  = 1'b1;
                end else begin
                    st_d.step = st_q.step + 1'b1;
                    if (is_bit_op(st_q.op) && st_q.step[0]) st_d.sh = sh_nx;
                    drv         = drive(st_q.op, st_d.step, st_d.sh[DATA_W]);
                    st_d.scl_oe = drv[1];
                    st_d.sda_oe = drv[0];
                end
            end
            // only the acknowledge level stays writable while busy
            if (reg_wr && reg_addr == ADDR_CTRL) st_d.ack_lvl = reg_wdata[BIT_ACK_LVL];
        end else if (reg_wr) begin
            case (reg_addr)
                ADDR_CTRL: begin
                    st_d.ack_lvl = reg_wdata[BIT_ACK_LVL];
                    if (pick_any) begin
                        st_d.op = pick_op;
                        st_d.sh = (pick_op == OP_ACK)
                                ? {reg_wdata[BIT_ACK_LVL], {DATA_W{1'b1}}} : '1;
                    end
                end
                ADDR_TX: begin
                    st_d.tx = reg_wdata;
                    st_d.op = OP_TX;
                    st_d.sh = {reg_wdata, 1'b1};
                end
                ADDR_DIV: st_d.div = reg_wdata[DIV_W-1:0];
                default: ;
            endcase
            if (st_d.op != OP_IDLE) begin
                st_d.step   = '0;
                drv         = drive(st_d.op, '0, st_d.sh[DATA_W]);
                st_d.scl_oe = drv[1];
                st_d.sda_oe = drv[0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                for (int i = 0; i < CMD_BITS; i++)
                    reg_rdata[i] = (st_q.op == op_e'(3'(i + 1)));
                reg_rdata[BIT_ACK_LVL]  = st_q.ack_lvl;
                reg_rdata[BIT_ACK_STAT] = st_q.ack_stat;
            end
            ADDR_TX:  reg_rdata = st_q.tx;
            ADDR_RX:  reg_rdata = st_q.rx;
            default:  reg_rdata = DATA_W'(st_q.div);
        endcase
    end

    assign scl_oe = st_q.scl_oe;
    assign sda_oe = st_q.sda_oe;
    assign irq    = st_q.irq;

    // R12: a command write during an event leaves the running event alone
    a_r12_cmd_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick && reg_wr && reg_addr == ADDR_CTRL) |=> $stable(st_q.op));

    // R12: transmit value is not overwritten while busy
    a_r12_tx_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_addr == ADDR_TX) |=> $stable(st_q.tx));

    // R12: divider is not overwritten while busy
    a_r12_div_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_addr == ADDR_DIV) |=> $stable(st_q.div));

    // R11: completion pulse lasts a single cycle
    a_r11_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R11: the pulse appears only as the engine returns to idle
    a_r11_irq_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!busy && $past(busy)));

    // R10: while SCL is released in a bit event, SDA holds until SCL falls
    a_r10_sda_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && is_bit_op(st_q.op) && !st_q.scl_oe) |=> (st_q.scl_oe || $stable(st_q.sda_oe)));

endmodule

// File: tb/i2c_seq_master_tb.sv
`timescale 1ns/1ps
module i2c_seq_master_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_wr;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata;
    wire  [7:0] reg_rdata;
    wire        scl_oe, sda_oe, irq;
    logic       pull;
    wire        sda_in = ~(sda_oe | pull);

    always #10 clk = ~clk;

    i2c_seq_master u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sda_in    (sda_in),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .irq       (irq)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Slave model and line monitor
    int         sl_mode = 0;   // 0 silent, 1 ack on ninth clock, 2 send sl_byte
    logic [7:0] sl_byte = 8'h00;
    logic       sl_ack  = 1'b0;
    int         fall_cnt = 0, fall_base = 0;
    int         n_start = 0, n_stop = 0, n_viol = 0;
    logic       in_bit = 1'b0;
    logic [8:0] cap = '0;
    logic       scl_prev = 1'b1, sda_prev = 1'b1;

    always_comb begin
        int rel;
        rel  = fall_cnt - fall_base;
        pull = 1'b0;
        if (sl_mode == 1 && rel == 8) pull = sl_ack;
        if (sl_mode == 2 && rel >= 0 && rel < 8) pull = ~sl_byte[3'(7 - rel)];
    end

    always @(negedge clk) begin
        logic scl_l, sda_l;
        scl_l = ~scl_oe;
        sda_l = ~(sda_oe | pull);
        if (scl_prev && scl_l) begin
            if (sda_prev && !sda_l) n_start++;
            if (!sda_prev && sda_l) n_stop++;
            if (in_bit && (sda_prev != sda_l)) n_viol++;
        end
        if (!scl_prev && scl_l) cap = {cap[7:0], sda_l};
        if (scl_prev && !scl_l) fall_cnt++;
        scl_prev = scl_l;
        sda_prev = sda_l;
    end

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Issue one event, check busy bits, duration and pulse width
    task automatic run_cmd(input logic [1:0] a, input logic [7:0] v, input int exp_cyc,
                           input logic [4:0] exp_bits, input string req);
        logic [7:0] r;
        int n;
        @(negedge clk);
        fall_base = fall_cnt;
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        rd(ADDR_CTRL_TB, r);
        check({req, " busy bits"}, int'(r[4:0]), int'(exp_bits));
        n = 0;
        while (n < 4000) begin
            @(negedge clk);
            n++;
            if (irq) break;
        end
        check({req, " R9 duration"}, n, exp_cyc);
        rd(ADDR_CTRL_TB, r);
        check({req, " R11 bits clear at irq"}, int'(r[4:0]), 0);
        @(negedge clk);
        check({req, " R11 pulse width"}, int'(irq), 0);
    endtask

    localparam logic [1:0] ADDR_CTRL_TB = 2'd0;

    task automatic do_start(input int d);
        int s0;
        s0 = n_start;
        run_cmd(2'd0, 8'h01, 3 * (d + 1), 5'b00001, "R2 start");
        check("R2 one SDA fall with SCL high", n_start - s0, 1);
        check("R2 final enables", int'({scl_oe, sda_oe}), 3);
    endtask

    task automatic do_rstart(input int d);
        int s0;
        s0 = n_start;
        run_cmd(2'd0, 8'h02, 4 * (d + 1), 5'b00010, "R3 rstart");
        check("R3 one SDA fall with SCL high", n_start - s0, 1);
        check("R3 final enables", int'({scl_oe, sda_oe}), 3);
    endtask

    task automatic do_stop(input int d);
        int s0;
        s0 = n_stop;
        run_cmd(2'd0, 8'h04, 3 * (d + 1), 5'b00100, "R4 stop");
        check("R4 one SDA rise with SCL high", n_stop - s0, 1);
        check("R4 final enables", int'({scl_oe, sda_oe}), 0);
    endtask

    task automatic do_tx(input logic [7:0] b, input logic ack_low, input int d);
        logic [7:0] r;
        int v0;
        sl_mode = 1; sl_ack = ack_low; v0 = n_viol; in_bit = 1'b1;
        run_cmd(2'd1, b, 18 * (d + 1), 5'b00000, "R5 tx");
        in_bit = 1'b0;
        check("R5 bits on line", int'(cap[8:1]), int'(b));
        rd(2'd0, r);
        check("R6 ack status", int'(r[6]), int'(!ack_low));
        rd(2'd1, r);
        check("R5 tx readback", int'(r), int'(b));
        check("R10 no SDA move with SCL high (tx)", n_viol - v0, 0);
        sl_mode = 0;
    endtask

    task automatic do_rx(input logic [7:0] b, input int d);
        logic [7:0] r;
        int v0;
        sl_mode = 2; sl_byte = b; v0 = n_viol; in_bit = 1'b1;
        run_cmd(2'd0, 8'h08, 16 * (d + 1), 5'b01000, "R7 rx");
        in_bit = 1'b0;
        rd(2'd2, r);
        check("R7 received byte", int'(r), int'(b));
        check("R10 no SDA move with SCL high (rx)", n_viol - v0, 0);
        sl_mode = 0;
    endtask

    task automatic do_ack(input logic lvl, input int d);
        int v0;
        v0 = n_viol; in_bit = 1'b1;
        run_cmd(2'd0, {2'b00, lvl, 5'b10000}, 2 * (d + 1), 5'b10000, "R8 ack");
        in_bit = 1'b0;
        check("R8 ack level on line", int'(cap[0]), int'(lvl));
        check("R10 no SDA move with SCL high (ack)", n_viol - v0, 0);
    endtask

    initial begin
        #(64'd200000 * 20);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), r);
            check("R1 register reset", int'(r), 0);
        end
        check("R1 enables released", int'({scl_oe, sda_oe}), 0);
        check("R1 irq low", int'(irq), 0);

        for (int d = 0; d < 4; d++) begin
            wr(2'd3, 8'(d));
            rd(2'd3, r);
            check("R9 divider readback", int'(r), d);
            do_start(d);
            if (d == 0) begin
                for (int b = 0; b < 256; b++) do_tx(8'(b), b[0], d);
                for (int b = 0; b < 256; b++) do_rx(8'(b), d);
            end else begin
                do_tx(8'h00, 1'b1, d); do_tx(8'hFF, 1'b0, d);
                do_tx(8'hA5, 1'b1, d); do_tx(8'h5A, 1'b0, d);
                do_rx(8'h00, d); do_rx(8'hFF, d); do_rx(8'hA5, d); do_rx(8'h5A, d);
            end
            do_ack(1'b0, d);
            do_ack(1'b1, d);
            do_rstart(d);
            do_tx(8'hC3, 1'b1, d);
            do_stop(d);
        end

        // R12: refused writes during a long receive (divider 3, last tx 0xC3)
        begin
            int n;
            int irqs;
            do_start(3);
            sl_mode = 2; sl_byte = 8'h96;
            @(negedge clk);
            fall_base = fall_cnt;
            wr(2'd0, 8'h08);
            wr(2'd0, 8'h01);
            rd(2'd0, r);
            check("R12 start refused while busy", int'(r[4:0]), 5'b01000);
            wr(2'd1, 8'h3C);
            wr(2'd3, 8'h07);
            n = 0;
            while (n < 4000 && !irq) begin @(negedge clk); n++; end
            @(negedge clk);
            sl_mode = 0;
            rd(2'd2, r);
            check("R12 receive unaffected", int'(r), 8'h96);
            rd(2'd1, r);
            check("R12 tx value kept", int'(r), 8'hC3);
            rd(2'd3, r);
            check("R12 divider kept", int'(r), 3);
            irqs = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (irq) irqs++;
            end
            rd(2'd0, r);
            check("R12 no event launched", int'(r[4:0]), 0);
            check("R12 no extra irq", irqs, 0);
            check("R12 SCL still held low", int'(scl_oe), 1);
        end

        // R13 priority among simultaneous requests (divider 3)
        do_stop(3);
        run_cmd(2'd0, 8'h1F, 12, 5'b00001, "R13 start wins");
        run_cmd(2'd0, 8'h1E, 16, 5'b00010, "R13 rstart wins");
        run_cmd(2'd0, 8'h1C, 12, 5'b00100, "R13 stop wins");
        do_start(3);
        run_cmd(2'd0, 8'h18, 64, 5'b01000, "R13 rx wins");
        rd(2'd2, r);
        check("R13 rx with silent slave", int'(r), 8'hFF);
        run_cmd(2'd0, 8'h30, 8, 5'b10000, "R13 ack alone");
        do_stop(3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule